// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block runs a bank of general-purpose I/O pins through two registers on a small synchronous register bus. A control word holds two bits per pin: one picks the direction and one controls a weak pull-up. A data word holds one latch bit per pin. Output pins drive their latch bit. Input pins are brought into the clock domain by a short flop chain and can be read back from the data word.

The block drives three vectors to the pad ring: output enable, output value and pull-up enable. The pull-up request is masked whenever a pin drives, so a pin never pulls against its own driver. The data latch has no reset. A value written before a reset is still on the pins after it, and it can be preloaded while the pins are still inputs.

Bus accesses take one cycle. Writes use byte strobes. Read data is registered and shows up on the cycle after the request, then holds until the next read.

Top module: `gpio_port`

## Requirements
- R1: Reset (synchronous, active high) clears the control word to all zeros. Every pin then has output enable 0 and pull-up enable 1, and a control read returns 0.
- R2: The output enable of pin n equals control bit 2n (0 = input, 1 = output).
- R3: The pull-up enable of pin n is 1 only when control bit 2n+1 is 0 and control bit 2n is 0. Bit 2n+1 = 1 disables the pull-up, and an output pin never has its pull-up enabled.
- R4: The output value of pin n is data-latch bit n. Writes reach the latch whatever the pin's direction, so a value written while a pin is an input is driven as soon as the pin becomes an output.
- R5: Reset does not change the data latch. Its contents and the pin output values are the same before and after a reset pulse.
- R6: A read of the data word (word address 1) returns latch bit n in bit n for each output pin. Bits 31:16 read 0.
- R7: A read of the data word returns the synchronized pad level for each input pin. A pad change made before clock edge k is seen by reads sampled at edge k+2 or later, and by no earlier read.
- R8: Byte strobe i (bit i of the strobe input) enables write-data bits 8i+7:8i. The control word (word address 0) uses strobes 0 to 3 and the data word uses strobes 0 to 1. Bytes whose strobe is low keep their value.
- R9: Read data is registered and valid one cycle after the request. Word addresses 2 and 3 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word address (0 control, 1 data) |
| bus_we | input | 1 | Write request |
| bus_re | input | 1 | Read request |
| bus_be | input | 4 | Byte strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Pad input levels |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output value |
| pad_pu | output | 16 | Per-pin pull-up enable |

## Verification
The bench uses the defaults: 16 pins, a two-bit word address and a two-stage synchronizer. With these values the control word fills the 32-bit bus exactly, so all four strobes reach real bytes. The two unmapped addresses can be reached, and the exact edge at which a pad change first becomes visible can be pinned down. Pin patterns that mix directions and pull-up settings exercise the masking and the per-bit readback select.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned WORD_CTRL = 0;
  localparam int unsigned WORD_DATA = 1;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_DATA = 2'd1,
    RSEL_NONE = 2'd2
  } rsel_e;
endpackage

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WIDTH/8-1:0] be,
  input  logic [WIDTH-1:0]   wdata,
  output logic [WIDTH-1:0]   ctrl_q
);
  localparam int unsigned NBYTES = WIDTH / 8;

  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && be[gb]) begin
        q <= wdata[gb*8 +: 8];
      end
    end
    assign ctrl_q[gb*8 +: 8] = q;
  end
endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch #(
  parameter int unsigned NPINS = 16
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [NPINS/8-1:0] be,
  input  logic [NPINS-1:0]   wdata,
  output logic [NPINS-1:0]   latch_q
);
  localparam int unsigned NBYTES = NPINS / 8;

  // No reset: contents survive every reset.
  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && be[gb]) begin
        q <= wdata[gb*8 +: 8];
      end
    end
    assign latch_q[gb*8 +: 8] = q;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] d,
  output logic [NPINS-1:0] q
);
  logic [NPINS-1:0] chain [STAGES];

  for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        chain[gs] <= '0;
      end else if (gs == 0) begin
        chain[gs] <= d;
      end else begin
        chain[gs] <= chain[(gs == 0) ? 0 : gs-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg #(
  parameter int unsigned NPINS = 16
) (
  input  logic [2*NPINS-1:0] ctrl_q,
  output logic [NPINS-1:0]   oe,
  output logic [NPINS-1:0]   pu
);
  for (genvar gp = 0; gp < NPINS; gp++) begin : g_pin
    logic dir_out;
    logic pu_off;
    assign dir_out = ctrl_q[2*gp];
    assign pu_off  = ctrl_q[2*gp+1];
    assign oe[gp]  = dir_out;
    assign pu[gp]  = ~pu_off & ~dir_out;
  end
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  rsel_e              sel,
  input  logic [2*NPINS-1:0] ctrl_q,
  input  logic [NPINS-1:0]   oe,
  input  logic [NPINS-1:0]   latch_q,
  input  logic [NPINS-1:0]   pin_sync,
  output logic [BUS_W-1:0]   rdata
);
  logic [NPINS-1:0] data_view;

  for (genvar gp = 0; gp < NPINS; gp++) begin : g_pick
    assign data_view[gp] = oe[gp] ? latch_q[gp] : pin_sync[gp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      unique case (sel)
        RSEL_CTRL: rdata <= BUS_W'(ctrl_q);
        RSEL_DATA: rdata <= BUS_W'(data_view);
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BUS_W      = 2 * NPINS,
  localparam int unsigned BE_W       = BUS_W / 8,
  localparam int unsigned DBE_W      = NPINS / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_pu
);
  logic             hit_ctrl;
  logic             hit_data;
  rsel_e            rsel;
  logic [BUS_W-1:0] ctrl_q;
  logic [NPINS-1:0] latch_q;
  logic [NPINS-1:0] pin_sync;

  assign hit_ctrl = (bus_addr == ADDR_W'(WORD_CTRL));
  assign hit_data = (bus_addr == ADDR_W'(WORD_DATA));

  always_comb begin
    if (hit_ctrl)      rsel = RSEL_CTRL;
    else if (hit_data) rsel = RSEL_DATA;
    else               rsel = RSEL_NONE;
  end

  gpio_ctrl_reg #(.WIDTH(BUS_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_we && hit_ctrl),
    .be     (bus_be),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q)
  );

  gpio_data_latch #(.NPINS(NPINS)) u_latch (
    .clk     (clk),
    .wr_en   (bus_we && hit_data),
    .be      (bus_be[DBE_W-1:0]),
    .wdata   (bus_wdata[NPINS-1:0]),
    .latch_q (latch_q)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_sync)
  );

  gpio_pin_cfg #(.NPINS(NPINS)) u_cfg (
    .ctrl_q (ctrl_q),
    .oe     (pad_oe),
    .pu     (pad_pu)
  );

  gpio_readback #(.NPINS(NPINS), .BUS_W(BUS_W)) u_rb (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_re),
    .sel      (rsel),
    .ctrl_q   (ctrl_q),
    .oe       (pad_oe),
    .latch_q  (latch_q),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata)
  );

  assign pad_out = latch_q;
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned BUS_W = 2 * NPINS,
  localparam int unsigned BE_W  = BUS_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [BE_W-1:0]   bus_be,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_pu
);
  logic rd_data;
  logic rd_unmapped;
  assign rd_data     = bus_re && (bus_addr == ADDR_W'(1));
  assign rd_unmapped = bus_re && (bus_addr > ADDR_W'(1));

  AST_RESET_CFG: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0) && (pad_pu == '1)); // R1

  AST_PU_MASKED: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_pu) == '0); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(bus_we && bus_addr == ADDR_W'(1)) && !$isunknown(pad_out))
      |=> $stable(pad_out)); // R5

  AST_OUT_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd_data && pad_oe == '1 && !bus_we)
      |=> bus_rdata == BUS_W'($past(pad_out))); // R6

  AST_IN_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd_data && pad_oe == '0 && !$past(rst) && !$past(rst, 2) &&
     pad_in == $past(pad_in) && pad_in == $past(pad_in, 2))
      |=> bus_rdata == BUS_W'($past(pad_in))); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_unmapped |=> bus_rdata == '0); // R9
endmodule

bind gpio_port gpio_port_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_pu    (pad_pu)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_oe, pad_out, pad_pu;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  logic [31:0] ctrl_m = '0;
  logic [15:0] data_m = '0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        re_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: one read result per request, one cycle later.
  always @(posedge clk) re_d <= bus_re;
  always @(negedge clk) begin
    if (re_d) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected read", bus_rdata, 32'hx);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [15:0] exp_oe(logic [31:0] c);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = c[2*i];
    return r;
  endfunction

  function automatic logic [15:0] exp_pu(logic [31:0] c);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = !c[2*i+1] && !c[2*i];
    return r;
  endfunction

  function automatic logic [31:0] exp_data(logic [31:0] c, logic [15:0] d, logic [15:0] p);
    logic [31:0] r = '0;
    for (int i = 0; i < 16; i++) r[i] = c[2*i] ? d[i] : p[i];
    return r;
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_be = be; bus_wdata = d;
    if (a == 2'd0) ctrl_m = merge(ctrl_m, d, be);
    if (a == 2'd1) data_m = merge({16'h0, data_m}, d, {2'b00, be[1:0]});
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  // Driver: issue a read and queue the value the monitor must see.
  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic pins(string tag);
    check({tag, " pad_oe"},  {16'h0, pad_oe},  {16'h0, exp_oe(ctrl_m)});
    check({tag, " pad_pu"},  {16'h0, pad_pu},  {16'h0, exp_pu(ctrl_m)});
    check({tag, " pad_out"}, {16'h0, pad_out}, {16'h0, data_m});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 oe after reset", {16'h0, pad_oe}, 32'h0);
    check("R1 pu after reset", {16'h0, pad_pu}, 32'h0000_ffff);
    rd(2'd0, 32'h0, "R1 ctrl read");

    // R4: preload latch while inputs; R7 input readback
    wr(2'd1, 32'h0000_a5c3, 4'b0011);
    check("R4 pad_out preload", {16'h0, pad_out}, 32'h0000_a5c3);
    pad_in = 16'h1234;
    repeat (3) @(negedge clk);
    rd(2'd1, 32'h0000_1234, "R7 input readback");

    // R2/R3/R6: all outputs
    wr(2'd0, 32'h5555_5555, 4'hf);
    pins("R2 R3 all out");
    rd(2'd1, 32'h0000_a5c3, "R6 output readback");
    rd(2'd0, 32'h5555_5555, "R1 ctrl readback");

    // Mixed directions and pull-up settings
    wr(2'd0, 32'hc8a0_1d33, 4'hf);
    pins("R3 mixed");
    rd(2'd1, exp_data(ctrl_m, data_m, pad_in), "R6 R7 mixed readback");

    // R8: byte strobes on control and data
    wr(2'd0, 32'h00ff_0000, 4'b0100);
    pins("R8 ctrl byte2");
    rd(2'd0, ctrl_m, "R8 ctrl strobe");
    wr(2'd0, 32'h0, 4'hf);
    wr(2'd0, 32'h5555_5555, 4'hf);
    wr(2'd1, 32'h0000_7e66, 4'b0001);
    check("R8 data low byte", {16'h0, pad_out}, 32'h0000_a566);
    rd(2'd1, 32'h0000_a566, "R8 data strobe");

    // R7: synchronizer latency, all inputs
    wr(2'd0, 32'h0, 4'hf);
    pad_in = 16'h0f0f;
    repeat (3) @(negedge clk);
    pad_in = 16'hf00f;           // change before next edge k
    bus_addr = 2'd1; bus_re = 1'b1;
    exp_q.push_back(32'h0000_0f0f); tag_q.push_back("R7 not yet at k");
    @(negedge clk);
    exp_q.push_back(32'h0000_0f0f); tag_q.push_back("R7 not yet at k+1");
    @(negedge clk);
    exp_q.push_back(32'h0000_f00f); tag_q.push_back("R7 visible at k+2");
    @(negedge clk);
    bus_re = 1'b0;

    // R9: unmapped and ignored writes
    wr(2'd2, 32'hffff_ffff, 4'hf);
    wr(2'd3, 32'hffff_ffff, 4'hf);
    pins("R9 ignored writes");
    rd(2'd2, 32'h0, "R9 unmapped 2");
    rd(2'd3, 32'h0, "R9 unmapped 3");

    // R5: latch survives reset
    wr(2'd1, 32'h0000_3c5a, 4'b0011);
    wr(2'd0, 32'h5555_5555, 4'hf);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    ctrl_m = '0;
    check("R5 pad_out after reset", {16'h0, pad_out}, 32'h0000_3c5a);
    pins("R1 after second reset");
    wr(2'd0, 32'h5555_5555, 4'hf);
    rd(2'd1, 32'h0000_3c5a, "R5 latch readback");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule